// File: doc/BRIEF.md
# Core Barrier Synchronization Unit

This block is a register-mapped slave that holds cores at a barrier. Each core has its own arrival slot on a small write bus. A core that writes its slot gets its own stall line raised on the next clock edge. The stall line stays high until the unit lets that core go. The release rule depends on one of two modes.

In all-arrive mode the unit counts distinct arrivals. The write that completes the set drops every stall line on the same edge, and the count then starts again from zero.

In master/worker mode one core, picked by a parameter, acts as the master:
- The other cores enter the barrier by writing their slots.
- The master announces that it is waiting by writing a dedicated offset. It is held until every worker has arrived.
- The master then runs alone while the workers stay held.
- A write by the master to a second dedicated offset frees all workers on one edge.

The controller states are:
- `ST_SYNC`: all-arrive mode.
- `ST_GATHER`: master/worker mode, master not yet waiting.
- `ST_MWAIT`: master held until the workers are in.
- `ST_SOLO`: master running alone, workers held.

The transitions are:
- A mode write that is accepted moves to `ST_SYNC` or `ST_GATHER`.
- `ST_GATHER` goes to `ST_MWAIT` on a master wait with workers missing.
- `ST_GATHER` goes to `ST_SOLO` on a master wait once all workers are in.
- `ST_MWAIT` goes to `ST_SOLO` on the last worker's arrival.
- `ST_SOLO` goes to `ST_GATHER` on a master release.

Address map, with N cores:
- Offsets 0..N-1 are the core slots.
- Offset N is the master wait.
- Offset N+1 is the master release.
- Offset N+2 is the mode register. Write-data bit 0 selects the mode: 0 for all-arrive, 1 for master/worker.

Top module: `barrier_sync_unit`

## Requirements
- R1: After reset every stall line is low and the mode register reads 0 (all-arrive mode).
- R2: In all-arrive mode, a write to slot i (other than the completing one) raises stall line i on the next edge and leaves the other lines unchanged.
- R3: A write to the slot of a core whose stall line is already high is not counted as an arrival and changes no stall line.
- R4: In all-arrive mode, the write by the last of the N distinct cores drops every stall line on the same edge, and the next barrier again needs N fresh arrivals.
- R5: A write to offset N+2 while no stall line is high sets the mode to bit 0 of the write data, and a read of N+2 returns it in bit 0.
- R6: A write to offset N+2 while any stall line is high is ignored: the mode read back is unchanged.
- R7: In master/worker mode, a worker slot write raises that worker's stall line, and a master wait (offset N) issued while any worker is missing raises the master's stall line.
- R8: While the master is held, the arrival of the last worker drops only the master's stall line on the next edge, and the workers stay held.
- R9: A master wait issued once all workers are held leaves the master's stall line low.
- R10: A master release (offset N+1) while the master runs alone drops every worker's stall line on the same edge. At any other time it changes nothing.
- R11: A master write to its own slot in master/worker mode, and any write to offsets N or N+1 in all-arrive mode, changes no stall line.
- R12: A read of slot i returns stall line i in bit 0. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | DATA_W | Write data (bit 0 used by the mode register) |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| core_stall | output | N | Per-core stall lines |

## Verification
The assertions take for granted that the bus carries at most one write per cycle. They also assume that a core issues no writes while its own stall line is high, apart from the deliberate repeats aimed at R3. The stimulus uses a single task that presents one write, then drops the strobe for at least one cycle. The bench sweeps every arrival order of four cores in all-arrive mode. In master/worker mode it sweeps every worker order crossed with every position of the master wait. This keeps each transition inside the one-access, in-order model that the properties assume.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    typedef enum logic [1:0] {
        ST_SYNC,
        ST_GATHER,
        ST_MWAIT,
        ST_SOLO
    } bsu_state_e;

    // Control offsets relative to the core count N
    localparam int OFS_MWAIT = 0;
    localparam int OFS_MREL  = 1;
    localparam int OFS_MODE  = 2;
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode #(
    parameter int N      = 4,
    parameter int ADDR_W = 4
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      slot_hit,
    output logic              mwait_hit,
    output logic              mrel_hit,
    output logic              mode_hit
);
    import bsu_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign slot_hit[i] = we && (addr == ADDR_W'(i));
    end

    assign mwait_hit = we && (addr == ADDR_W'(N + OFS_MWAIT));
    assign mrel_hit  = we && (addr == ADDR_W'(N + OFS_MREL));
    assign mode_hit  = we && (addr == ADDR_W'(N + OFS_MODE));
endmodule

// File: rtl/bsu_arrival.sv
module bsu_arrival #(
    parameter int N = 4,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit #(
    parameter int N         = 4,
    parameter int MASTER_ID = 0,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N-1:0]      core_stall
);
    import bsu_pkg::*;

    localparam int CNT_W = $clog2(N + 1);

    bsu_state_e       state_q, state_d;
    logic [N-1:0]     stall_q, stall_d;
    logic [N-1:0]     slot_hit, eligible, arrive_vec;
    logic             mwait_hit, mrel_hit, mode_hit;
    logic             arrive, is_tp, all_workers, last_worker;
    logic             sync_done, mode_ok, cnt_clr;
    logic [CNT_W-1:0] count;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:1];

    bsu_decode #(.N(N), .ADDR_W(ADDR_W)) u_dec (
        .we        (bus_we),
        .addr      (bus_addr),
        .slot_hit  (slot_hit),
        .mwait_hit (mwait_hit),
        .mrel_hit  (mrel_hit),
        .mode_hit  (mode_hit)
    );

    assign is_tp = (state_q != ST_SYNC);

    always_comb begin
        eligible = '1;
        if (is_tp) eligible[MASTER_ID] = 1'b0;
    end

    assign arrive_vec  = slot_hit & eligible & ~stall_q;
    assign arrive      = |arrive_vec;
    assign all_workers = (count == CNT_W'(N - 1));
    assign last_worker = arrive && (count == CNT_W'(N - 2));
    assign sync_done   = (state_q == ST_SYNC) && arrive && all_workers;
    assign mode_ok     = mode_hit && (stall_q == '0);
    assign cnt_clr     = sync_done || mode_ok || ((state_q == ST_SOLO) && mrel_hit);

    bsu_arrival #(.N(N)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (arrive),
        .clr   (cnt_clr),
        .count (count)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (mode_ok) begin
            state_d = bus_wdata[0] ? ST_GATHER : ST_SYNC;
        end else begin
            unique case (state_q)
                ST_SYNC:   state_d = ST_SYNC;
                ST_GATHER: if (mwait_hit) state_d = all_workers ? ST_SOLO : ST_MWAIT;
                ST_MWAIT:  if (last_worker) state_d = ST_SOLO;
                ST_SOLO:   if (mrel_hit) state_d = ST_GATHER;
            endcase
        end
    end

    // Stall-line logic
    always_comb begin
        stall_d = stall_q | arrive_vec;
        unique case (state_q)
            ST_SYNC:   if (sync_done) stall_d = '0;
            ST_GATHER: if (mwait_hit && !all_workers) stall_d[MASTER_ID] = 1'b1;
            ST_MWAIT:  if (last_worker) stall_d[MASTER_ID] = 1'b0;
            ST_SOLO:   if (mrel_hit) stall_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stall_q <= '0;
        else        stall_q <= stall_d;
    end

    assign core_stall = stall_q;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata[0] = stall_q[i];
        end
        if (bus_addr == ADDR_W'(N + OFS_MODE)) bus_rdata[0] = is_tp;
    end
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
    import bsu_pkg::*;
#(
    parameter int N         = 4,
    parameter int MASTER_ID = 0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         we,
    input logic [N-1:0] stall,
    input bsu_state_e   state
);
    localparam logic [N-1:0] WORKER_MASK = ~(N'(1) << MASTER_ID);

    // R2
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stall & ~$past(stall)) != '0) |-> $past(we));

    // R4
    sync_full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SYNC) && ($past(state) == ST_SYNC) && ($past(stall) != '0) && (stall == '0))
        |-> ($countones($past(stall)) == N - 1));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall != '0) |=> ((state == ST_SYNC) == ($past(state) == ST_SYNC)));

    // R7
    master_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MWAIT) |-> stall[MASTER_ID]);

    // R8
    solo_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOLO) |-> (!stall[MASTER_ID] && ((stall & WORKER_MASK) == WORKER_MASK)));

    // R10
    worker_group_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(stall) & ~stall) & WORKER_MASK) != '0) |-> ((stall & WORKER_MASK) == '0));
endmodule

bind barrier_sync_unit bsu_checker #(.N(N), .MASTER_ID(MASTER_ID)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .stall (stall_q),
    .state (state_q)
);

// File: tb/barrier_sync_unit_tb.sv
module barrier_sync_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_MWAIT = 4'd4;
    localparam logic [AW-1:0] A_MREL  = 4'd5;
    localparam logic [AW-1:0] A_MODE  = 4'd6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  core_stall;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    barrier_sync_unit #(.N(N), .MASTER_ID(0), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .core_stall (core_stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [DW-1:0] rv;
        logic [N-1:0]  exp;
        int            order[N];
        int            wk[3];
        int            k;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 stall after reset", 32'(core_stall), 0);
        rd(A_MODE, rv);
        check("R1 mode after reset", rv, 0);
        rd(4'd7, rv);
        check("R12 unmapped read", rv, 0);

        wr(A_MWAIT, 0);
        check("R11 master wait in sync mode", 32'(core_stall), 0);
        wr(A_MREL, 0);
        check("R11 master release in sync mode", 32'(core_stall), 0);

        // All-arrive mode: every arrival order of four cores
        for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
        for (int c = 0; c < N; c++)
        for (int d = 0; d < N; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            order[0] = a; order[1] = b; order[2] = c; order[3] = d;
            exp = '0;
            for (int j = 0; j < N; j++) begin
                wr(AW'(order[j]), 1);
                exp[order[j]] = 1'b1;
                if (j == N - 1) begin
                    exp = '0;
                    check("R4 last arrival frees all", 32'(core_stall), 32'(exp));
                end else begin
                    check("R2 arrival stalls core", 32'(core_stall), 32'(exp));
                end
                if (j == 0) begin
                    wr(AW'(order[0]), 1);
                    check("R3 repeat arrival ignored", 32'(core_stall), 32'(exp));
                    rd(AW'(order[0]), rv);
                    check("R12 slot read", rv, 1);
                    wr(A_MODE, 1);
                    check("R6 mode write under stall", 32'(core_stall), 32'(exp));
                    rd(A_MODE, rv);
                    check("R6 mode unchanged", rv, 0);
                end
            end
        end

        wr(A_MODE, 1);
        rd(A_MODE, rv);
        check("R5 mode set to master/worker", rv, 1);

        // Master/worker mode: worker orders crossed with master-wait position
        for (int x = 1; x < N; x++)
        for (int y = 1; y < N; y++)
        for (int z = 1; z < N; z++) begin
            if (x == y || x == z || y == z) continue;
            wk[0] = x; wk[1] = y; wk[2] = z;
            for (int p = 0; p < N; p++) begin
                exp = '0;
                k = 0;
                wr(A_MREL, 0);
                check("R10 release outside solo ignored", 32'(core_stall), 0);
                wr(4'd0, 1);
                check("R11 master slot write ignored", 32'(core_stall), 0);
                for (int s = 0; s < N; s++) begin
                    if (s == p) begin
                        wr(A_MWAIT, 0);
                        exp[0] = (k < N - 1);
                        if (k == N - 1)
                            check("R9 late master not held", 32'(core_stall), 32'(exp));
                        else
                            check("R7 master held", 32'(core_stall), 32'(exp));
                    end else begin
                        wr(AW'(wk[k]), 1);
                        exp[wk[k]] = 1'b1;
                        k++;
                        if (k == N - 1 && exp[0]) begin
                            exp[0] = 1'b0;
                            check("R8 master freed alone", 32'(core_stall), 32'(exp));
                        end else begin
                            check("R7 worker held", 32'(core_stall), 32'(exp));
                        end
                    end
                end
                wr(A_MODE, 0);
                rd(A_MODE, rv);
                check("R6 mode held in solo", rv, 1);
                wr(AW'(wk[0]), 1);
                check("R3 held worker rewrite ignored", 32'(core_stall), 32'(exp));
                wr(A_MREL, 0);
                check("R10 release frees workers", 32'(core_stall), 0);
            end
        end

        wr(A_MODE, 0);
        rd(A_MODE, rv);
        check("R5 mode back to all-arrive", rv, 0);
        wr(4'd2, 1);
        check("R2 arrival after mode change", 32'(core_stall), 32'h4);

        summary();
    end
endmodule